// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block makes the SCL waveform of an I2C master from the system clock. A configuration word holds three fields: an 8-bit divider for the low phase, an 8-bit divider for the high phase, and one power-of-two prescaler exponent that both phases share. Each phase lasts `divider * 2^exponent + OFFSET` system clocks. `OFFSET` is a fixed per-variant parameter, usually 3 or 4. The largest exponent is a parameter, usually 5 or 7. A symmetric setting therefore gives an SCL frequency of `f_sys / (2 * (div * 2^exp + OFFSET))`.

Along with the SCL level, the block gives a transfer sequencer two one-cycle strobes. The drive strobe comes in the first cycle of each low phase, which is when SDA may change. The sample strobe comes at the midpoint of each high phase, which is when SDA is read.

The configuration is read only where a phase begins, so a rewrite never cuts a phase short. While the enable is low, SCL is released high and the phase state is held cleared.

Top module: `scl_clk_gen`

## Requirements
- R1: The configuration word places the shared exponent in bits 16 and up (width `EXP_W`), the high-phase divider in bits 15:8 and the low-phase divider in bits 7:0.
- R2: Once enabled, each low phase lasts exactly `low_div * 2^e + OFFSET` clock cycles, where `e` is the effective exponent.
- R3: Each high phase lasts exactly `high_div * 2^e + OFFSET` clock cycles.
- R4: An exponent field larger than `MAX_EXP` acts as `MAX_EXP`.
- R5: The length of a phase comes from the configuration sampled at the clock edge where that phase begins. Later changes act only from the next phase boundary.
- R6: While `en` is low, `scl` is 1 and both strobes are 0. After a disable, whether during a phase or not, the next enable starts a complete low phase.
- R7: When `en` is sampled high while idle, `scl` goes low right after that clock edge, so the waveform always begins with a low phase.
- R8: `drive_stb` is high for exactly one cycle per low phase, and that cycle is the first cycle of the low phase.
- R9: `sample_stb` is high for exactly one cycle per high phase, at cycle index `floor(L/2)` counted from 0, where `L` is that phase's length.
- R10: `sample_stb` and `drive_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Enable. When low, SCL is released and the state is cleared |
| cfg | input | 16+EXP_W | Configuration word: exponent, high divider and low divider |
| scl | output | 1 | SCL level (1 = released/high) |
| sample_stb | output | 1 | One-cycle strobe at the midpoint of each high phase |
| drive_stb | output | 1 | One-cycle strobe in the first cycle of each low phase |

## Verification
The bench builds the block with `OFFSET` = 3 and `MAX_EXP` = 5. The exponent field stays 3 bits wide, so the codes 6 and 7 are legal inputs that must be clamped. With these values every exponent code can be swept against several low and high dividers, and the bench compares the measured phase lengths and strobe positions with figures it computes itself. Because phases stay short, the run also reaches the all-ones dividers at the clamped exponent, a configuration rewrite in the middle of a phase, and a disable in the middle of a phase.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;

  function automatic int unsigned exp_bits(input int unsigned max_exp);
    return (max_exp < 1) ? 1 : $clog2(max_exp + 1);
  endfunction

  function automatic int unsigned len_bits(input int unsigned div_w,
                                           input int unsigned max_exp,
                                           input int unsigned offset);
    return $clog2(((2 ** div_w) - 1) * (2 ** max_exp) + offset + 1);
  endfunction
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned MAX_EXP = 7,
  parameter int unsigned OFFSET  = 4,
  parameter int unsigned LEN_W   = 16
) (
  input  logic [DIV_W-1:0] div,
  input  logic [EXP_W-1:0] exp_raw,
  output logic [LEN_W-1:0] len
);
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);
  logic [EXP_W-1:0] exp_eff;

  always_comb begin
    exp_eff = (exp_raw > EXP_CAP) ? EXP_CAP : exp_raw;
    len     = (LEN_W'(div) << exp_eff) + LEN_W'(OFFSET);
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] len_low,
  input  logic [LEN_W-1:0] len_high,
  output logic             active,
  output scl_phase_e       phase,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] len_cur
);
  logic             active_d;
  scl_phase_e       phase_d;
  logic [LEN_W-1:0] cnt_d;
  logic [LEN_W-1:0] len_d;
  logic             upd_en;
  logic             last_cyc;

  assign upd_en   = en | active;
  assign last_cyc = (cnt == len_cur - LEN_W'(1));

  always_comb begin
    active_d = active;
    phase_d  = phase;
    cnt_d    = cnt;
    len_d    = len_cur;
    if (!en) begin
      active_d = 1'b0;
      phase_d  = PH_LOW;
      cnt_d    = '0;
      len_d    = '0;
    end else if (!active) begin
      active_d = 1'b1;
      phase_d  = PH_LOW;
      cnt_d    = '0;
      len_d    = len_low;
    end else if (last_cyc) begin
      cnt_d = '0;
      if (phase == PH_LOW) begin
        phase_d = PH_HIGH;
        len_d   = len_high;
      end else begin
        phase_d = PH_LOW;
        len_d   = len_low;
      end
    end else begin
      cnt_d = cnt + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= PH_LOW;
      cnt     <= '0;
      len_cur <= '0;
    end else if (upd_en) begin
      active  <= active_d;
      phase   <= phase_d;
      cnt     <= cnt_d;
      len_cur <= len_d;
    end
  end
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             active,
  input  scl_phase_e       phase,
  input  logic [LEN_W-1:0] cnt,
  input  logic [LEN_W-1:0] len_cur,
  output logic             scl,
  output logic             sample_stb,
  output logic             drive_stb
);
  always_comb begin
    scl        = !active || (phase == PH_HIGH);
    drive_stb  = active && (phase == PH_LOW)  && (cnt == '0);
    sample_stb = active && (phase == PH_HIGH) && (cnt == (len_cur >> 1));
  end
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
  import scl_pkg::*;
#(
  parameter int unsigned OFFSET  = 4,
  parameter int unsigned MAX_EXP = 7,
  parameter int unsigned EXP_W   = exp_bits(MAX_EXP),
  parameter int unsigned CFG_W   = 16 + EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg,
  output logic             scl,
  output logic             sample_stb,
  output logic             drive_stb
);
  localparam int unsigned DIV_W = 8;
  localparam int unsigned LEN_W = len_bits(DIV_W, MAX_EXP, OFFSET);
  localparam int unsigned EXP_LSB = 2 * DIV_W;

  logic             rst_sync_n;
  logic [LEN_W-1:0] len_sel [2];
  logic             active;
  scl_phase_e       phase;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_cur;

  scl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // index 0: low-phase divider in bits 7:0; index 1: high-phase divider in bits 15:8
  for (genvar g = 0; g < 2; g++) begin : g_len
    scl_phase_len #(
      .DIV_W   (DIV_W),
      .EXP_W   (EXP_W),
      .MAX_EXP (MAX_EXP),
      .OFFSET  (OFFSET),
      .LEN_W   (LEN_W)
    ) u_len (
      .div     (cfg[g*DIV_W +: DIV_W]),
      .exp_raw (cfg[EXP_LSB +: EXP_W]),
      .len     (len_sel[g])
    );
  end

  scl_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (en),
    .len_low  (len_sel[0]),
    .len_high (len_sel[1]),
    .active   (active),
    .phase    (phase),
    .cnt      (cnt),
    .len_cur  (len_cur)
  );

  scl_strobe_gen #(.LEN_W(LEN_W)) u_stb (
    .active     (active),
    .phase      (phase),
    .cnt        (cnt),
    .len_cur    (len_cur),
    .scl        (scl),
    .sample_stb (sample_stb),
    .drive_stb  (drive_stb)
  );
endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk #(
  parameter int unsigned OFFSET  = 4,
  parameter int unsigned MAX_EXP = 7,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned CFG_W   = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CFG_W-1:0] cfg,
  input logic             scl,
  input logic             sample_stb,
  input logic             drive_stb
);
  int unsigned cfg_low_len_q;
  int unsigned lo_exp_q;
  int unsigned lo_run_q;

  function automatic int unsigned low_len_of(input logic [CFG_W-1:0] c);
    int unsigned e;
    e = int'(c[16 +: EXP_W]);
    if (e > MAX_EXP) e = MAX_EXP;
    return int'(c[7:0]) * (1 << e) + OFFSET;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_low_len_q <= 0;
      lo_exp_q      <= 0;
      lo_run_q      <= 0;
    end else begin
      cfg_low_len_q <= low_len_of(cfg);
      if (drive_stb) begin
        lo_exp_q <= cfg_low_len_q;
        lo_run_q <= 1;
      end else if (!scl) begin
        lo_run_q <= lo_run_q + 1;
      end
    end
  end

  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !sample_stb && !drive_stb));

  p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scl && !$past(en)) |=> !scl);

  p_drive_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |-> $fell(scl));

  p_sample_in_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (scl && en));

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && drive_stb));

  p_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl) && en && $past(en)) |-> (lo_run_q == lo_exp_q));
endmodule

bind scl_clk_gen scl_clk_gen_chk #(
  .OFFSET  (OFFSET),
  .MAX_EXP (MAX_EXP),
  .EXP_W   (EXP_W),
  .CFG_W   (CFG_W)
) u_chk (.*);

// File: tb/scl_clk_gen_tb.sv
module scl_clk_gen_tb_top;
  localparam int OFF   = 3;
  localparam int MAXE  = 5;
  localparam int EXPW  = 3;
  localparam int CFGW  = 16 + EXPW;
  localparam int LIMIT = 40000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic [CFGW-1:0] cfg = '0;
  logic            scl, sample_stb, drive_stb;
  int n_cmp = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scl_clk_gen #(.OFFSET(OFF), .MAX_EXP(MAXE)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg),
    .scl(scl), .sample_stb(sample_stb), .drive_stb(drive_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int plen(input int d, input int e);
    int ee;
    ee = (e > MAXE) ? MAXE : e;
    return d * (1 << ee) + OFF;
  endfunction

  // R1 field layout: exponent [16 +: EXPW], high divider [15:8], low divider [7:0]
  function automatic logic [CFGW-1:0] mk(input int e, input int dh, input int dl);
    return {EXPW'(e), 8'(dh), 8'(dl)};
  endfunction

  task automatic measure(input logic [CFGW-1:0] c, input bit mid, input logic [CFGW-1:0] c2);
    int lo, hi, spos, nsamp, e, el, eh;
    bit both, bad_drive;
    logic [CFGW-1:0] hc;
    e = int'(c[16 +: EXPW]);
    @(negedge clk); cfg = c; en = 1'b1;
    @(negedge clk);
    chk(scl == 1'b0, "R7 scl low after enable", scl, 0);
    chk(drive_stb == 1'b1, "R8 drive on first low cycle", drive_stb, 1);
    if (mid) cfg = c2;
    lo = 0; both = 0; bad_drive = 0;
    while (scl == 1'b0 && lo < LIMIT) begin
      if (drive_stb && lo != 0) bad_drive = 1;
      if (drive_stb && sample_stb) both = 1;
      lo++;
      @(negedge clk);
    end
    el = plen(int'(c[7:0]), e);
    chk(lo == el, (e > MAXE) ? "R4 clamped low length" : (mid ? "R5 low kept" : "R2 low length"), lo, el);
    chk(!bad_drive, "R8 single drive strobe", bad_drive, 0);
    hc = mid ? c2 : c;
    eh = plen(int'(hc[15:8]), int'(hc[16 +: EXPW]));
    hi = 0; spos = -1; nsamp = 0;
    while (scl == 1'b1 && hi < LIMIT) begin
      if (sample_stb) begin nsamp++; spos = hi; end
      if (drive_stb) bad_drive = 1;
      if (drive_stb && sample_stb) both = 1;
      hi++;
      @(negedge clk);
    end
    chk(hi == eh, mid ? "R5 new high length" : "R3 high length", hi, eh);
    chk(nsamp == 1 && spos == eh / 2, "R9 sample position", spos, eh / 2);
    chk(drive_stb == 1'b1 && !bad_drive, "R8 drive at next low", drive_stb, 1);
    chk(!both, "R10 strobes exclusive", both, 0);
    en = 1'b0;
    @(negedge clk);
    chk(scl && !sample_stb && !drive_stb, "R6 released when disabled", scl, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl == 1'b1, "R6 reset scl high", scl, 1);
    chk(!sample_stb && !drive_stb, "R6 reset strobes low", sample_stb | drive_stb, 0);

    for (int e = 0; e < 8; e++)
      for (int dl = 0; dl < 8; dl += 3)
        for (int dh = 0; dh < 6; dh += 5)
          measure(mk(e, dh, dl), 1'b0, '0);

    measure(mk(MAXE, 255, 255), 1'b0, '0);
    measure(mk(7, 255, 1), 1'b0, '0);
    measure(mk(0, 0, 0), 1'b0, '0);
    measure(mk(0, 2, 9), 1'b0, '0);

    measure(mk(2, 3, 5), 1'b1, mk(1, 7, 1));
    measure(mk(0, 1, 4), 1'b1, mk(3, 2, 2));

    @(negedge clk); cfg = mk(1, 6, 4); en = 1'b1;
    while (scl == 1'b0) @(negedge clk);
    repeat (2) @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(scl && !sample_stb && !drive_stb, "R6 mid-phase disable", scl, 1);
    end
    measure(mk(1, 6, 4), 1'b0, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule